// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers every interrupt source of a small CPU subsystem and presents the core with one request line and the vector number of the winning source. It takes one non-maskable input, eight external request pins, sixteen key-sense inputs and twenty-six internal peripheral requests. Every pin input passes through a two-flop synchronizer. The non-maskable input is caught on an edge whose direction software selects. Each external pin is sensed either on a low level or on a falling edge.

The key-sense inputs are active low. Each one has a mask bit. The enabled key inputs are merged with external pin 6, so a pressed key appears as a low level on that line. Software programs the control bits through a one-cycle write port. The CPU takes an interrupt by pulsing an acknowledge while the request is high. On that acknowledge the controller sets its global mask bit and clears the latched edge flag of the source that was served.

Top module: `vic_top`

## Requirements
- R1: After reset the request is low, the vector is 0, the global mask is 1, every external enable is 0, every key mask bit is 1 (key disabled) and the non-maskable input selects the falling edge. In this state low pins and low keys raise no request, even once the global mask is cleared.
- R2: The non-maskable input requests vector 3 on its falling edge when control bit 1 is 0, and on its rising edge when that bit is 1. The opposite edge raises nothing. The request is raised whether or not the global mask is set.
- R3: A sense bit of 1 makes external pin n falling-edge sensed. The edge is latched even while the global mask is set, and it is served once the mask clears. A sense bit of 0 makes the pin level sensed: it requests only while the pin is low, and a low pulse that ends before the mask clears leaves nothing behind.
- R4: External pin n requests only while its enable bit n is 1.
- R5: While the global mask (control bit 0) is 1, no external pin and no internal source can raise a request. Only vector 3 can.
- R6: Pin n uses vector 4+n and internal request k uses vector 12+k. When several sources request at once, the lowest vector number wins. This makes the non-maskable input first, then pins 0 to 7, then internal sources in ascending order.
- R7: Key input j is enabled when key-mask bit j is 0. An enabled key held low requests vector 10, the same as a low pin 6. A masked key has no effect.
- R8: An acknowledge in a cycle where the request is high sets the global mask to 1, drops the request in the next cycle, and clears the latched edge flag of the served vector.
- R9: While the request is high and not acknowledged, the request and the vector stay unchanged, even if a higher-priority source appears or the winning source withdraws.
- R10: A write with select 0 loads the global mask from data bit 0 and the edge select from data bit 1. Select 1 loads the eight sense bits. Select 2 loads the eight enables. Select 3 loads the sixteen key-mask bits. A write takes effect from the next cycle, and an acknowledge in the same cycle wins over a written mask value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Non-maskable interrupt pin (asynchronous) |
| irq_pin_i | input | 8 | External request pins (asynchronous) |
| key_i | input | 16 | Key-sense inputs, active low (asynchronous) |
| int_req_i | input | 26 | Internal peripheral requests, active high, synchronous |
| wr_en_i | input | 1 | Control register write strobe |
| wr_sel_i | input | 2 | Control register select |
| wr_data_i | input | 16 | Control register write data |
| cpu_ack_i | input | 1 | CPU accepts the presented vector |
| cpu_req_o | output | 1 | Interrupt request to the CPU |
| cpu_vec_o | output | 6 | Vector number of the presented request |
| gmask_o | output | 1 | Current global mask bit |

## Verification
Random mixes of low external pins and internal request bits are applied together, with the mask held so that all of them reach arbitration in the same cycle. This separates an ordering fault between pins and internal sources, or within either group, from a fault in the vector offsets. Directed sequences then drive short pulses against the mask in level mode and in edge mode. A pulse that must be latched and a pulse that must vanish give different results, and a second mask release after an acknowledge shows whether the latched flag was really cleared. A higher-priority arrival and a withdrawing source during an unacknowledged request show whether the vector is held, and edges of both directions on the non-maskable input tell the two polarity settings apart.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int unsigned VIC_N_IRQ     = 8;
    localparam int unsigned VIC_N_KEY     = 16;
    localparam int unsigned VIC_N_INT     = 26;
    localparam int unsigned VIC_KEY_IRQ   = 6;
    localparam int unsigned VIC_SYNC      = 2;
    localparam int unsigned VIC_VEC_NMI   = 3;

    // control bit positions inside a SEL_CTRL write
    localparam int unsigned CTRL_GMASK_BIT = 0;
    localparam int unsigned CTRL_RISE_BIT  = 1;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_SENSE  = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_KMASK  = 2'd3
    } vic_sel_e;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {(STAGES*W){RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/vic_ext.sv
// Edge / level detection for the non-maskable input and the external lines.
module vic_ext #(
    parameter int unsigned N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_s_i,
    input  logic [N_IRQ-1:0] line_s_i,
    input  logic             nmi_rise_i,
    input  logic [N_IRQ-1:0] sense_i,
    input  logic [N_IRQ-1:0] en_i,
    input  logic             clr_nmi_i,
    input  logic [N_IRQ-1:0] clr_irq_i,
    output logic             nmi_req_o,
    output logic [N_IRQ-1:0] irq_req_o
);
    typedef struct packed {
        logic             nmi_prev;
        logic             nmi_pend;
        logic [N_IRQ-1:0] line_prev;
        logic [N_IRQ-1:0] pend;
    } ext_st_t;

    ext_st_t st_d, st_q;
    logic             nmi_edge;
    logic [N_IRQ-1:0] fall;
    logic [N_IRQ-1:0] edge_mode;

    always_comb begin
        nmi_edge  = nmi_rise_i ? (nmi_s_i & ~st_q.nmi_prev)
                               : (~nmi_s_i & st_q.nmi_prev);
        fall      = ~line_s_i & st_q.line_prev;
        edge_mode = en_i & sense_i;

        st_d           = st_q;
        st_d.nmi_prev  = nmi_s_i;
        st_d.line_prev = line_s_i;
        // a fresh edge wins over a clear in the same cycle
        st_d.nmi_pend  = nmi_edge | (st_q.nmi_pend & ~clr_nmi_i);
        st_d.pend      = edge_mode & (fall | (st_q.pend & ~clr_irq_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.nmi_prev  <= 1'b0;
            st_q.nmi_pend  <= 1'b0;
            st_q.line_prev <= '1;
            st_q.pend      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nmi_req_o = st_q.nmi_pend;
    assign irq_req_o = en_i & ((sense_i & st_q.pend) | (~sense_i & ~line_s_i));
endmodule

// File: rtl/vic_prio.sv
// Lowest-index-wins priority encoder.
module vic_prio #(
    parameter int unsigned N = 38,
    parameter int unsigned W = 6
) (
    input  logic [N-1:0] req_i,
    output logic         valid_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = W'(i);
        end
        valid_o = |req_i;
    end
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int unsigned N_IRQ       = VIC_N_IRQ,
    parameter int unsigned N_KEY       = VIC_N_KEY,
    parameter int unsigned N_INT       = VIC_N_INT,
    parameter int unsigned KEY_IRQ     = VIC_KEY_IRQ,
    parameter int unsigned SYNC_STAGES = VIC_SYNC,
    parameter int unsigned VEC_NMI     = VIC_VEC_NMI,
    localparam int unsigned VEC_IRQ0   = VEC_NMI + 1,
    localparam int unsigned VEC_INT0   = VEC_IRQ0 + N_IRQ,
    localparam int unsigned VEC_TOTAL  = VEC_INT0 + N_INT,
    localparam int unsigned VEC_W      = $clog2(VEC_TOTAL),
    localparam int unsigned WR_W       = (N_KEY > N_IRQ) ? N_KEY : N_IRQ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_i,
    input  logic [N_IRQ-1:0]  irq_pin_i,
    input  logic [N_KEY-1:0]  key_i,
    input  logic [N_INT-1:0]  int_req_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [WR_W-1:0]   wr_data_i,
    input  logic              cpu_ack_i,
    output logic              cpu_req_o,
    output logic [VEC_W-1:0]  cpu_vec_o,
    output logic              gmask_o
);
    typedef struct packed {
        logic             nmi_rise;
        logic             gmask;
        logic [N_IRQ-1:0] sense;
        logic [N_IRQ-1:0] en;
        logic [N_KEY-1:0] kmask;
        logic             req;
        logic [VEC_W-1:0] vec;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             nmi_s;
    logic [N_IRQ-1:0] pin_s;
    logic [N_KEY-1:0] key_s;
    logic             key_hit;
    logic [N_IRQ-1:0] line_s;
    logic             nmi_req;
    logic [N_IRQ-1:0] irq_req;
    logic [VEC_TOTAL-1:0] req_vec;
    logic             win_valid;
    logic [VEC_W-1:0] win_idx;
    logic             accept;
    logic             clr_nmi;
    logic [N_IRQ-1:0] clr_irq;

    // ---------------- synchronizers ----------------
    vic_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_nmi (
        .clk(clk), .rst_n(rst_n), .d_i(nmi_i), .q_o(nmi_s)
    );
    vic_sync #(.W(N_IRQ), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pin (
        .clk(clk), .rst_n(rst_n), .d_i(irq_pin_i), .q_o(pin_s)
    );
    vic_sync #(.W(N_KEY), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_key (
        .clk(clk), .rst_n(rst_n), .d_i(key_i), .q_o(key_s)
    );

    // ---------------- key merge onto one line ----------------
    always_comb begin
        key_hit         = |(~key_s & ~st_q.kmask);
        line_s          = pin_s;
        line_s[KEY_IRQ] = pin_s[KEY_IRQ] & ~key_hit;
    end

    // ---------------- detection ----------------
    vic_ext #(.N_IRQ(N_IRQ)) u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_s_i    (nmi_s),
        .line_s_i   (line_s),
        .nmi_rise_i (st_q.nmi_rise),
        .sense_i    (st_q.sense),
        .en_i       (st_q.en),
        .clr_nmi_i  (clr_nmi),
        .clr_irq_i  (clr_irq),
        .nmi_req_o  (nmi_req),
        .irq_req_o  (irq_req)
    );

    // ---------------- request map by vector number ----------------
    always_comb begin
        req_vec          = '0;
        req_vec[VEC_NMI] = nmi_req;
        for (int n = 0; n < N_IRQ; n++) begin
            req_vec[VEC_IRQ0 + n] = irq_req[n] & ~st_q.gmask;
        end
        for (int k = 0; k < N_INT; k++) begin
            req_vec[VEC_INT0 + k] = int_req_i[k] & ~st_q.gmask;
        end
    end

    vic_prio #(.N(VEC_TOTAL), .W(VEC_W)) u_prio (
        .req_i   (req_vec),
        .valid_o (win_valid),
        .idx_o   (win_idx)
    );

    // ---------------- acknowledge decode ----------------
    assign accept  = st_q.req & cpu_ack_i;
    assign clr_nmi = accept & (st_q.vec == VEC_W'(VEC_NMI));

    generate
        for (genvar g = 0; g < N_IRQ; g++) begin : g_clr
            assign clr_irq[g] = accept & (st_q.vec == VEC_W'(VEC_IRQ0 + g));
        end
    endgenerate

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;

        if (wr_en_i) begin
            case (vic_sel_e'(wr_sel_i))
                SEL_CTRL: begin
                    st_d.gmask    = wr_data_i[CTRL_GMASK_BIT];
                    st_d.nmi_rise = wr_data_i[CTRL_RISE_BIT];
                end
                SEL_SENSE:  st_d.sense = wr_data_i[N_IRQ-1:0];
                SEL_ENABLE: st_d.en    = wr_data_i[N_IRQ-1:0];
                SEL_KMASK:  st_d.kmask = wr_data_i[N_KEY-1:0];
                default: ;
            endcase
        end

        if (!st_q.req) begin
            if (win_valid) begin
                st_d.req = 1'b1;
                st_d.vec = win_idx;
            end
        end else if (cpu_ack_i) begin
            st_d.req   = 1'b0;
            st_d.gmask = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.nmi_rise <= 1'b0;
            st_q.gmask    <= 1'b1;
            st_q.sense    <= '0;
            st_q.en       <= '0;
            st_q.kmask    <= '1;
            st_q.req      <= 1'b0;
            st_q.vec      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_req_o = st_q.req;
    assign cpu_vec_o = st_q.vec;
    assign gmask_o   = st_q.gmask;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter int unsigned VEC_W   = 6,
    parameter int unsigned VEC_NMI = 3,
    parameter int unsigned VEC_MAX = 37
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_req_o,
    input logic [VEC_W-1:0] cpu_vec_o,
    input logic             cpu_ack_i,
    input logic             gmask_o
);
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_o && !cpu_ack_i) |=> (cpu_req_o && $stable(cpu_vec_o))); // R9

    AST_ACK_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_o && cpu_ack_i) |=> gmask_o); // R8

    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_o && cpu_ack_i) |=> !cpu_req_o); // R8

    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_o |-> (cpu_vec_o >= VEC_W'(VEC_NMI) && cpu_vec_o <= VEC_W'(VEC_MAX))); // R6

    AST_MASKED_ONLY_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_req_o) && $past(gmask_o)) |-> (cpu_vec_o == VEC_W'(VEC_NMI))); // R5
endmodule

bind vic_top vic_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req_o (cpu_req_o),
    .cpu_vec_o (cpu_vec_o),
    .cpu_ack_i (cpu_ack_i),
    .gmask_o   (gmask_o)
);

// File: tb/sim_vic_top.sv
`timescale 1ns/1ps
module sim_vic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi = 1'b0;
    logic [7:0]  pins = 8'hFF;
    logic [15:0] keys = 16'hFFFF;
    logic [25:0] ints = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        ack = 1'b0;
    logic        req;
    logic [5:0]  vec;
    logic        gmask;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic rise_sh = 1'b0;

    always #4 clk = ~clk;

    vic_top u0 (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .irq_pin_i(pins), .key_i(keys),
        .int_req_i(ints), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .cpu_ack_i(ack), .cpu_req_o(req), .cpu_vec_o(vec), .gmask_o(gmask)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ctrl(input logic gm);
        wr(2'd0, {14'd0, rise_sh, gm});
    endtask

    task automatic wait_req(output bit got);
        got = 0;
        for (int i = 0; i < 16; i++) begin
            if (req) begin got = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic expect_vec(input string tag, input int exp);
        bit got;
        int first;
        wait_req(got);
        chk({tag, " request raised"}, int'(got), 1);
        if (got) begin
            first = int'(vec);
            chk({tag, " vector"}, first, exp);
            repeat (3) @(negedge clk);
            chk({tag, " R9 vector held"}, int'(vec), first);
            chk({tag, " R9 request held"}, int'(req), 1);
            ack = 1'b1;
            @(negedge clk);
            ack = 1'b0;
            chk({tag, " R8 request dropped"}, int'(req), 0);
            chk({tag, " R8 mask set"}, int'(gmask), 1);
        end
    endtask

    task automatic expect_none(input string tag);
        repeat (10) @(negedge clk);
        chk({tag, " no request"}, int'(req), 0);
    endtask

    function automatic int exp_vec(input logic [7:0] p, input logic [25:0] q);
        for (int n = 0; n < 8; n++) if (!p[n]) return 4 + n;
        for (int k = 0; k < 26; k++) if (q[k]) return 12 + k;
        return 0;
    endfunction

    initial begin
        logic [7:0]  rp;
        logic [25:0] ri;
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 reset request", int'(req), 0);
        chk("R1 reset vector", int'(vec), 0);
        chk("R1 reset mask", int'(gmask), 1);
        pins = 8'h00; keys = 16'h0000;
        set_ctrl(1'b0);
        chk("R10 mask cleared by write", int'(gmask), 0);
        expect_none("R1 enables off, keys masked");
        pins = 8'hFF; keys = 16'hFFFF;
        set_ctrl(1'b1);
        repeat (4) @(negedge clk);

        // R2: non-maskable edge selection, mask set
        nmi = 1'b1;
        expect_none("R2 rising ignored in falling mode");
        nmi = 1'b0;
        expect_vec("R2 falling edge", 3);
        rise_sh = 1'b1;
        set_ctrl(1'b1);
        nmi = 1'b1;
        expect_vec("R2 rising edge", 3);
        nmi = 1'b0;
        expect_none("R2 falling ignored in rising mode");

        // R3: edge-sensed pin 2 latched while masked
        wr(2'd1, 16'h0004);
        wr(2'd2, 16'h0004);
        pins[2] = 1'b0; repeat (3) @(negedge clk);
        pins[2] = 1'b1; repeat (6) @(negedge clk);
        chk("R5 masked edge not presented", int'(req), 0);
        set_ctrl(1'b0);
        expect_vec("R3 latched edge", 6);
        set_ctrl(1'b0);
        expect_none("R8 edge flag cleared by ack");
        // R3: level mode leaves nothing behind
        wr(2'd1, 16'h0000);
        set_ctrl(1'b1);
        pins[2] = 1'b0; repeat (4) @(negedge clk);
        pins[2] = 1'b1; repeat (4) @(negedge clk);
        set_ctrl(1'b0);
        expect_none("R3 released level not latched");
        pins[2] = 1'b0;
        expect_vec("R3 low level", 6);
        pins[2] = 1'b1; repeat (4) @(negedge clk);

        // R4: enable gating
        wr(2'd2, 16'h0000);
        set_ctrl(1'b0);
        pins[1] = 1'b0;
        expect_none("R4 disabled pin");
        wr(2'd2, 16'h0002);
        expect_vec("R4 enabled pin", 5);
        pins = 8'hFF; repeat (4) @(negedge clk);

        // R5: mask blocks pins and internal, not the non-maskable input
        rise_sh = 1'b0;
        set_ctrl(1'b1);
        wr(2'd2, 16'h0004);
        pins[2] = 1'b0; ints[3] = 1'b1;
        expect_none("R5 maskables blocked");
        nmi = 1'b1; repeat (4) @(negedge clk);
        nmi = 1'b0;
        expect_vec("R5 non-maskable through mask", 3);
        set_ctrl(1'b0);
        expect_vec("R6 pin over internal", 6);
        pins = 8'hFF; ints = '0; repeat (4) @(negedge clk);

        // R7: key sense merged onto line 6
        wr(2'd2, 16'h0040);
        wr(2'd3, 16'hFFDF);
        keys[9] = 1'b0;
        set_ctrl(1'b0);
        expect_none("R7 masked key ignored");
        keys[5] = 1'b0;
        expect_vec("R7 enabled key", 10);
        keys = 16'hFFFF; repeat (4) @(negedge clk);
        pins[6] = 1'b0;
        set_ctrl(1'b0);
        expect_vec("R7 pin 6 still active", 10);
        pins = 8'hFF; repeat (4) @(negedge clk);

        // R9: vector held while unacknowledged
        wr(2'd2, 16'h00FF);
        set_ctrl(1'b1);
        pins[3] = 1'b0; repeat (4) @(negedge clk);
        set_ctrl(1'b0);
        begin
            bit got;
            wait_req(got);
            chk("R9 first request", int'(got), 1);
            chk("R9 first vector", int'(vec), 7);
            pins[0] = 1'b0; ints[0] = 1'b1;
            repeat (3) @(negedge clk);
            pins[3] = 1'b1;
            repeat (4) @(negedge clk);
            chk("R9 vector held against higher arrival", int'(vec), 7);
            chk("R9 request held", int'(req), 1);
            ack = 1'b1; @(negedge clk); ack = 1'b0;
            chk("R8 mask after ack", int'(gmask), 1);
        end
        set_ctrl(1'b0);
        expect_vec("R6 pin 0 first", 4);
        pins = 8'hFF; repeat (4) @(negedge clk);
        set_ctrl(1'b0);
        expect_vec("R6 internal 0", 12);
        ints = '0; repeat (4) @(negedge clk);

        // R6: random mixes of pins and internal requests
        for (int it = 0; it < 30; it++) begin
            rp = 8'($urandom);
            ri = 26'($urandom);
            if (it % 3 == 0) rp = 8'hFF;
            if (rp == 8'hFF && ri == '0) ri[25] = 1'b1;
            pins = rp; ints = ri;
            repeat (4) @(negedge clk);
            set_ctrl(1'b0);
            expect_vec("R6 random priority", exp_vec(rp, ri));
            pins = 8'hFF; ints = '0;
            repeat (4) @(negedge clk);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule